// File: doc/BRIEF.md
# Serial Command Front-End for a Single-Wiper Digital Potentiometer

This block is the digital side of a one-wiper potentiometer. A host talks to it over a three-wire SPI-style slave link (active-low select, serial clock, data in) plus a separate data-out pin with its own output enable. Each command frame starts when select goes low. The first byte names the device: a fixed four-bit type code and two address bits that must match two strap pins on the board. The second byte carries an opcode and picks one of sixteen 8-bit data registers, organised as four banks of four. The third byte is either write data from the host or read data sent back to it. Register-to-wiper transfers need only the first two bytes.

The block holds the sixteen data registers and the 8-bit wiper register. It presents the wiper value on a parallel output and pulses a one-cycle strobe each time that value is loaded. The serial pins are oversampled by the system clock through synchronisers. Serial clock edges are found inside the block, so the host clock must be several times slower than the system clock.

Top module: `pot_spi_front`

## Requirements
- R1: After reset the wiper output equals the reset value (0x80 by default), the strobe is low, the data-out enable is low and every data register reads 0x00.
- R2: If the upper nibble of the first byte after select falls is not 0101, the device ignores the rest of the frame and no register changes.
- R3: Bits [1:0] of the first byte must equal the two address strap pins, or the frame is ignored. Bits [3:2] of that byte are don't-care.
- R4: In the second byte, bits [7:4] are the opcode, bits [3:2] are the register pointer and bits [1:0] are the bank. The target register index is bank*4+pointer. If bit 0 is 1, the frame is aimed at a second wiper that does not exist and is discarded, so there is no write and no read drive.
- R5: Opcode 0100 writes the third byte into the addressed data register. Opcode 0011 returns that register in the third byte. The sixteen registers are independent.
- R6: Opcode 0010 loads the third byte into the wiper register. Opcode 0001 returns the wiper register in the third byte and leaves it unchanged.
- R7: Opcode 0101 copies the addressed data register into the wiper, and opcode 0110 copies the wiper into the addressed data register. Both act at the end of the second byte, and only when the bank is 0. With any other bank nothing changes.
- R8: Any opcode other than 0001 to 0110 is ignored.
- R9: Data in is sampled on rising serial clock edges, most significant bit first. Read data updates after falling edges: the first bit appears after the falling edge that follows the last rising edge of the second byte. The data-out enable is high only while the read byte is being sent, and is low whenever select is high.
- R10: A select rise aborts the frame, and a register changes only when all eight bits of its data byte have arrived. A rising serial clock edge that reaches the block in the same cycle as the select rise is not counted.
- R11: Every write or transfer into the wiper register updates the wiper output and raises the wiper strobe for exactly one system clock cycle. The wiper output never changes without the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| addr_pins | input | 2 | Board strap address compared with bits [1:0] of the first byte |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Enable for the external tristate driver on the read data pin |
| wiper | output | 8 | Current wiper register value |
| wiper_stb | output | 1 | One-cycle pulse when the wiper register is loaded |

## Verification
Frame abort and byte commit can meet in one cycle. The host raises select and the final data-bit clock edge together, so both pass through the synchronisers in the same system clock cycle. The bench provokes this on a wiper write whose first seven bits were already clocked in. It then reads the wiper back and expects the old value with no strobe, since the scoreboard queue holds no entry for that frame. A cleanly aborted frame, with select raised in the middle of the data byte, is checked the same way.

// File: rtl/pot_spi_pkg.sv
package pot_spi_pkg;

   localparam logic [3:0] OP_RD_WIPER = 4'h1;
   localparam logic [3:0] OP_WR_WIPER = 4'h2;
   localparam logic [3:0] OP_RD_REG   = 4'h3;
   localparam logic [3:0] OP_WR_REG   = 4'h4;
   localparam logic [3:0] OP_REG2WIP  = 4'h5;
   localparam logic [3:0] OP_WIP2REG  = 4'h6;

   typedef enum logic [2:0] {
      ST_ID,
      ST_INSTR,
      ST_WDATA,
      ST_READ,
      ST_HOLD
   } frame_st_e;

endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pot_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/pot_rx.sv
module pot_rx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              rise,
   input  logic              din,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_val
);

   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-2:0] sr;

   assign byte_vld = active && rise && (cnt == LAST);
   assign byte_val = {sr, din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sr  <= '0;
      end else if (!active) begin
         cnt <= '0;
      end else if (rise) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         sr  <= {sr[BYTE_W-3:0], din};
      end
   end

endmodule

// File: rtl/pot_tx.sv
module pot_tx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              en,
   input  logic              fall,
   output logic              sdo
);

   logic [BYTE_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         sdo <= 1'b0;
      end else if (load) begin
         sr  <= load_val;
      end else if (en && fall) begin
         sdo <= sr[BYTE_W-1];
         sr  <= {sr[BYTE_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/pot_regs.sv
module pot_regs #(
   parameter int                BYTE_W    = 8,
   parameter int                N_REGS    = 16,
   parameter logic [BYTE_W-1:0] WIPER_RST = 8'h80,
   localparam int               IDX_W     = $clog2(N_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_widx,
   input  logic [BYTE_W-1:0] reg_wval,
   input  logic [IDX_W-1:0]  reg_ridx,
   output logic [BYTE_W-1:0] reg_rval,
   input  logic              wip_we,
   input  logic [BYTE_W-1:0] wip_wval,
   output logic [BYTE_W-1:0] wiper,
   output logic              wiper_stb
);

   logic [BYTE_W-1:0] regs [N_REGS];

   for (genvar i = 0; i < N_REGS; i++) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (reg_we && reg_widx == IDX_W'(i)) q <= reg_wval;
      end
      assign regs[i] = q;
   end

   assign reg_rval = regs[reg_ridx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper     <= WIPER_RST;
         wiper_stb <= 1'b0;
      end else begin
         wiper_stb <= wip_we;
         if (wip_we) wiper <= wip_wval;
      end
   end

endmodule

// File: rtl/pot_spi_front.sv
module pot_spi_front
   import pot_spi_pkg::*;
#(
   parameter int                BYTE_W        = 8,
   parameter int                N_BANKS       = 4,
   parameter int                REGS_PER_BANK = 4,
   parameter int                ADDR_W        = 2,
   parameter int                SYNC_STAGES   = 2,
   parameter logic [3:0]        DEV_TYPE      = 4'b0101,
   parameter logic [BYTE_W-1:0] WIPER_RST     = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              sdi,
   input  logic [ADDR_W-1:0] addr_pins,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [BYTE_W-1:0] wiper,
   output logic              wiper_stb
);

   localparam int N_REGS = N_BANKS * REGS_PER_BANK;
   localparam int IDX_W  = $clog2(N_REGS);
   localparam int PTR_W  = $clog2(REGS_PER_BANK);
   localparam int BANK_W = $clog2(N_BANKS);

   // The byte layout fixes these: opcode nibble, 2-bit pointer, 2-bit bank.
   if (BYTE_W != 8 || N_BANKS != 4 || REGS_PER_BANK != 4 || ADDR_W != 2) begin : g_bad_fmt
      $error("pot_spi_front: byte layout needs 8-bit bytes, 4x4 registers, 2 strap pins");
   end

   logic cs_s, sck_s, sdi_s, sck_d;
   logic cs_act, sck_rise, sck_fall;

   pot_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, sdi}),
      .q     ({cs_s, sck_s, sdi_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign cs_act   = ~cs_s;
   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;

   logic              byte_vld;
   logic [BYTE_W-1:0] byte_val;

   pot_rx #(.BYTE_W(BYTE_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (cs_act),
      .rise     (sck_rise),
      .din      (sdi_s),
      .byte_vld (byte_vld),
      .byte_val (byte_val)
   );

   // Field decode of the byte just completed
   logic [3:0]        f_op;
   logic [PTR_W-1:0]  f_ptr;
   logic [BANK_W-1:0] f_bank;
   logic [IDX_W-1:0]  f_idx;
   logic              f_p0, f_bank0, id_ok;

   assign f_op    = byte_val[7:4];
   assign f_ptr   = byte_val[3:2];
   assign f_bank  = byte_val[1:0];
   assign f_idx   = {f_bank, f_ptr};
   assign f_p0    = byte_val[0];
   assign f_bank0 = (f_bank == '0);
   assign id_ok   = (byte_val[7:4] == DEV_TYPE) && (byte_val[ADDR_W-1:0] == addr_pins);

   frame_st_e        st;
   logic [3:0]       op_l;
   logic [IDX_W-1:0] idx_l;

   logic              instr_go, data_go;
   logic              reg_we, wip_we, tx_load;
   logic [IDX_W-1:0]  reg_widx;
   logic [BYTE_W-1:0] reg_wval, wip_wval, reg_rval, tx_val;

   assign instr_go = byte_vld && (st == ST_INSTR) && !f_p0;
   assign data_go  = byte_vld && (st == ST_WDATA);

   always_comb begin
      wip_we   = (instr_go && f_op == OP_REG2WIP && f_bank0) ||
                 (data_go && op_l == OP_WR_WIPER);
      wip_wval = data_go ? byte_val : reg_rval;
      reg_we   = (instr_go && f_op == OP_WIP2REG && f_bank0) ||
                 (data_go && op_l == OP_WR_REG);
      reg_widx = data_go ? idx_l : f_idx;
      reg_wval = data_go ? byte_val : wiper;
      tx_load  = instr_go && (f_op == OP_RD_WIPER || f_op == OP_RD_REG);
      tx_val   = (f_op == OP_RD_WIPER) ? wiper : reg_rval;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_ID;
         op_l  <= '0;
         idx_l <= '0;
      end else if (!cs_act) begin
         st <= ST_ID;
      end else if (byte_vld) begin
         unique case (st)
            ST_ID:    st <= id_ok ? ST_INSTR : ST_HOLD;
            ST_INSTR: begin
               op_l  <= f_op;
               idx_l <= f_idx;
               if (tx_load)
                  st <= ST_READ;
               else if (instr_go && (f_op == OP_WR_WIPER || f_op == OP_WR_REG))
                  st <= ST_WDATA;
               else
                  st <= ST_HOLD;
            end
            default:  st <= ST_HOLD;
         endcase
      end
   end

   assign sdo_oe = (st == ST_READ);

   pot_tx #(.BYTE_W(BYTE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tx_load),
      .load_val (tx_val),
      .en       (sdo_oe),
      .fall     (sck_fall),
      .sdo      (sdo)
   );

   pot_regs #(
      .BYTE_W    (BYTE_W),
      .N_REGS    (N_REGS),
      .WIPER_RST (WIPER_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_widx  (reg_widx),
      .reg_wval  (reg_wval),
      .reg_ridx  (f_idx),
      .reg_rval  (reg_rval),
      .wip_we    (wip_we),
      .wip_wval  (wip_wval),
      .wiper     (wiper),
      .wiper_stb (wiper_stb)
   );

endmodule

// File: rtl/pot_spi_chk.sv
module pot_spi_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cs_act,
   input logic         sdo_oe,
   input logic [W-1:0] wiper,
   input logic         wiper_stb
);

   p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wiper_stb |=> !wiper_stb);

   p_wiper_needs_stb_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper != $past(wiper)) |-> wiper_stb);

   p_idle_keeps_wiper_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> $stable(wiper));

   p_idle_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !sdo_oe);

   p_read_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !wiper_stb);

endmodule

bind pot_spi_front pot_spi_chk #(.W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_act    (cs_act),
   .sdo_oe    (sdo_oe),
   .wiper     (wiper),
   .wiper_stb (wiper_stb)
);

// File: tb/sim_pot_spi_front.sv
module sim_pot_spi_front;

   localparam int HALF = 6;
   localparam logic [7:0] ID = 8'h52;   // type 0101, strap 10

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic       sdi = 1'b0;
   logic [1:0] addr_pins = 2'b10;
   logic       sdo, sdo_oe, wiper_stb;
   logic [7:0] wiper;

   always #10 clk = ~clk;

   pot_spi_front u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sck       (sck),
      .sdi       (sdi),
      .addr_pins (addr_pins),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe),
      .wiper     (wiper),
      .wiper_stb (wiper_stb)
   );

   int checks = 0;
   int fails = 0;
   logic [7:0] exp_q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic hc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic r, output logic oe);
      sdi = b;
      hc(HALF);
      r  = sdo;
      oe = sdo_oe;
      sck = 1'b1;
      hc(HALF);
      sck = 1'b0;
   endtask

   task automatic byte_x(input logic [7:0] tb, output logic [7:0] rb,
                         output logic oe_all, output logic oe_any);
      logic r, oe;
      oe_all = 1'b1;
      oe_any = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         bit_x(tb[i], r, oe);
         rb[i]  = r;
         oe_all = oe_all & oe;
         oe_any = oe_any | oe;
      end
   endtask

   task automatic f_start();
      cs_n = 1'b0;
      hc(HALF);
   endtask

   task automatic f_end();
      hc(HALF);
      cs_n = 1'b1;
      hc(3 * HALF);
   endtask

   // Frame of two or three bytes; returns the third byte as seen on sdo.
   task automatic frame(input logic [7:0] id, input logic [7:0] ins, input logic [7:0] dat,
                        input bit three, output logic [7:0] rb,
                        output logic oe_all, output logic oe_any);
      logic [7:0] dummy;
      logic a, b;
      f_start();
      byte_x(id, dummy, a, b);
      byte_x(ins, dummy, a, b);
      rb = 8'h00; oe_all = 1'b0; oe_any = 1'b0;
      if (three) byte_x(dat, rb, oe_all, oe_any);
      f_end();
   endtask

   task automatic wr(input logic [7:0] id, input logic [7:0] ins, input logic [7:0] dat);
      logic [7:0] rb; logic a, b;
      frame(id, ins, dat, 1'b1, rb, a, b);
   endtask

   task automatic xfer(input logic [7:0] ins);
      logic [7:0] rb; logic a, b;
      frame(ID, ins, 8'h00, 1'b0, rb, a, b);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] ins, input logic [7:0] exp);
      logic [7:0] rb; logic a, b;
      frame(ID, ins, 8'h00, 1'b1, rb, a, b);
      chk(req, rb, exp, "read byte");
      chk("R9", a, 1'b1, "sdo_oe during read byte");
   endtask

   // Scoreboard monitor: every wiper strobe must match the next queued value
   always @(negedge clk) begin
      if (rst_n && wiper_stb) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R11 unexpected wiper strobe actual=%0h expected=none", wiper);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (wiper !== e) begin
               fails++;
               $display("FAIL R11 wiper on strobe actual=%0h expected=%0h", wiper, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] rb;
      logic oe_a, oe_o, r, oe;
      hc(5);
      rst_n = 1'b1;
      hc(4);

      // R1 reset state
      chk("R1", wiper, 8'h80, "wiper after reset");
      chk("R1", wiper_stb, 1'b0, "strobe after reset");
      chk("R1", sdo_oe, 1'b0, "sdo_oe after reset");
      rd_chk("R1", 8'h38, 8'h00);

      // R6 R9 wiper read and write, MSB first
      rd_chk("R6", 8'h10, 8'h80);
      exp_q.push_back(8'h3C);
      wr(ID, 8'h20, 8'h3C);
      rd_chk("R6", 8'h10, 8'h3C);

      // R5 data registers, R4 bank/pointer decode
      wr(ID, 8'h44, 8'hA5);                // bank 0 ptr 1
      rd_chk("R5", 8'h34, 8'hA5);
      wr(ID, 8'h4E, 8'h5A);                // bank 2 ptr 3
      rd_chk("R4", 8'h3E, 8'h5A);
      rd_chk("R4", 8'h3C, 8'h00);          // bank 0 ptr 3 untouched

      // R7 transfers, bank 0 only
      exp_q.push_back(8'hA5);
      xfer(8'h54);                         // reg 1 -> wiper
      rd_chk("R7", 8'h10, 8'hA5);
      xfer(8'h5E);                         // bank 2: rejected
      rd_chk("R7", 8'h10, 8'hA5);
      xfer(8'h68);                         // wiper -> bank 0 ptr 2
      rd_chk("R7", 8'h38, 8'hA5);
      xfer(8'h6A);                         // bank 2 ptr 2: rejected
      rd_chk("R7", 8'h3A, 8'h00);

      // R2 wrong type code
      wr(8'h72, 8'h20, 8'h11);
      rd_chk("R2", 8'h10, 8'hA5);
      // R3 bits [3:2] don't care, then wrong strap address
      exp_q.push_back(8'h77);
      wr(8'h5E, 8'h20, 8'h77);
      rd_chk("R3", 8'h10, 8'h77);
      wr(8'h51, 8'h20, 8'h11);
      rd_chk("R3", 8'h10, 8'h77);

      // R4 pot-select bit set: discarded
      wr(ID, 8'h21, 8'h22);
      rd_chk("R4", 8'h10, 8'h77);
      wr(ID, 8'h40, 8'h99);                // bank 0 ptr 0 = 99
      wr(ID, 8'h41, 8'h33);                // discarded
      rd_chk("R4", 8'h30, 8'h99);
      frame(ID, 8'h31, 8'h00, 1'b1, rb, oe_a, oe_o);
      chk("R4", oe_o, 1'b0, "sdo_oe on discarded read");

      // R8 undefined opcodes
      wr(ID, 8'h70, 8'h33);
      wr(ID, 8'h00, 8'h44);
      wr(ID, 8'hF0, 8'h55);
      rd_chk("R8", 8'h10, 8'h77);
      rd_chk("R8", 8'h30, 8'h99);

      // R10 abort mid data byte
      f_start();
      byte_x(ID, rb, oe_a, oe_o);
      byte_x(8'h20, rb, oe_a, oe_o);
      for (int i = 0; i < 4; i++) bit_x(1'b1, r, oe);
      f_end();
      rd_chk("R10", 8'h10, 8'h77);

      // R10 select rise together with the final clock edge
      f_start();
      byte_x(ID, rb, oe_a, oe_o);
      byte_x(8'h20, rb, oe_a, oe_o);
      for (int i = 0; i < 7; i++) bit_x(1'b0, r, oe);
      sdi = 1'b1;
      hc(HALF);
      sck  = 1'b1;
      cs_n = 1'b1;
      hc(HALF);
      sck = 1'b0;
      hc(3 * HALF);
      rd_chk("R10", 8'h10, 8'h77);

      // R9 idle, R11 scoreboard drained
      chk("R9", sdo_oe, 1'b0, "sdo_oe idle");
      chk("R11", exp_q.size(), 0, "pending wiper strobes");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule